// File: doc/BRIEF.md
# Flash Status-Poll Completion Checker

This block sits on the host side of a parallel flash link. It runs after a program or erase command has already been written to the memory. It decides whether that operation finished correctly. A one-cycle start pulse gives it two things: the address to poll and the byte that should end up in the array. For an erase, that byte is all ones. The checker then issues status reads to that address through a request/acknowledge handshake with the memory bus interface. It compares the top bit of each returned byte against the top bit of the expected byte.

While the top bit still differs and the exceeded-time flag (bit 5) is clear, the checker keeps polling. Once bit 5 is set, the checker does not fail at once. The two bits can flip in the same read, so it takes one more status read and compares the top bit again. After a match, the lower bits are not yet trustworthy. A further read is therefore taken, and that byte is presented as the final data.

A read-count limit can be set to force a failure when no decision comes. When the checker finishes, it pulses done for one cycle together with either pass or fail. It holds the resulting byte on its data output until the next accepted start.

Top module: `flash_poll_checker`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `pass_o` and `fail_o` are 0 and `data_o` is 0.
- R2: Every read request presents the address captured at the accepted start, and that address stays unchanged until done.
- R3: If a status byte's bit 7 equals bit 7 of the expected byte, exactly one further read is issued. The checker then reports pass, and `data_o` shows the byte returned by that further read.
- R4: If bit 7 differs and bit 5 of the status byte is 0, and the read limit has not been reached, another status read is issued.
- R5: If bit 7 differs and bit 5 is 1, one recheck read is issued. A bit-7 match on the recheck leads to the final read and to pass.
- R6: If the recheck byte's bit 7 still differs, the checker reports fail without a further read, and `data_o` shows the recheck byte.
- R7: Only bit 7 of the expected byte takes part in the comparison. Bits 6..0 of the status and expected bytes never change the outcome. An erase is checked by passing 0xFF as the expected byte.
- R8: `done_o` is high for exactly one cycle per operation, with exactly one of `pass_o` and `fail_o` high in that cycle and both low otherwise.
- R9: With `MAX_READS` nonzero, if a status read with bit 7 differing and bit 5 clear is the `MAX_READS`-th status read of the operation, the checker reports fail. `data_o` then shows that byte. A value of 0 disables the limit.
- R10: A start pulse while an operation is in progress is ignored. No second operation and no second done follow.
- R11: A read request stays asserted until the cycle in which `rd_ack_i` is high, and the returned byte is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a completion check |
| addr_i | input | AW | Address to poll, sampled with start |
| expect_i | input | DW | Expected byte (0xFF for erase), sampled with start |
| rd_req_o | output | 1 | Read request to the bus interface |
| rd_addr_o | output | AW | Address of the requested read |
| rd_ack_i | input | 1 | Read completion from the bus interface |
| rd_data_i | input | DW | Byte returned with `rd_ack_i` |
| done_o | output | 1 | One-cycle pulse marking the verdict |
| pass_o | output | 1 | Operation succeeded, valid with `done_o` |
| fail_o | output | 1 | Operation failed, valid with `done_o` |
| data_o | output | DW | Final byte, held until the next accepted start |

## Verification
A wrong control state shows at the ports within a read or two. The symptoms are:
- the request line rising too often, or too rarely, compared with the number of bytes the bench model consumes;
- the verdict arriving a read early, typically by skipping the recheck or the trailing read;
- the held byte coming from the wrong read.

Scripted byte sequences make each branch (retry, recheck, final read, limit) deliver a distinct byte. A mis-branch then changes the read count or `data_o` of that very operation. A lost address or an early drop of the request is caught at the handshake on the same read.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ1,
        ST_CHECK1,
        ST_READ2,
        ST_CHECK2,
        ST_FINAL,
        ST_DONE
    } poll_state_e;

    typedef enum logic [1:0] {
        DEC_FINAL,
        DEC_RETRY,
        DEC_RECHECK,
        DEC_FAIL
    } poll_dec_e;

endpackage

// File: rtl/poll_decide.sv
module poll_decide
    import poll_pkg::*;
#(
    parameter int DW       = 8,
    parameter int POLL_BIT = DW - 1,
    parameter int TIME_BIT = 5
) (
    input  logic [DW-1:0] stat_i,
    input  logic [DW-1:0] exp_i,
    input  logic          recheck_i,
    input  logic          limit_i,
    output poll_dec_e     dec_o
);

    localparam logic [DW-1:0] POLL_MASK = DW'(1) << POLL_BIT;
    localparam logic [DW-1:0] TIME_MASK = DW'(1) << TIME_BIT;

    logic toggled_w;
    logic timed_w;

    always_comb begin
        toggled_w = |((stat_i ^ exp_i) & POLL_MASK);
        timed_w   = |(stat_i & TIME_MASK);
        if (!toggled_w) begin
            dec_o = DEC_FINAL;
        end else if (recheck_i) begin
            dec_o = DEC_FAIL;
        end else if (timed_w) begin
            dec_o = DEC_RECHECK;
        end else if (limit_i) begin
            dec_o = DEC_FAIL;
        end else begin
            dec_o = DEC_RETRY;
        end
    end

endmodule

// File: rtl/poll_wdog.sv
module poll_wdog #(
    parameter int MAX_READS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);

    generate
        if (MAX_READS == 0) begin : g_off
            assign expired_o = 1'b0;
        end else begin : g_on
            localparam int CW = $clog2(MAX_READS + 1);
            localparam logic [CW-1:0] LIMIT = CW'(MAX_READS);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (tick_i && cnt_q != LIMIT) begin
                    cnt_d = cnt_q + CW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expired_o = (cnt_q >= LIMIT);

            AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LIMIT); // R9
        end
    endgenerate

endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
    import poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 8,
    parameter int TIME_BIT  = 5,
    parameter int MAX_READS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] expect_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        poll_state_e   state;
        logic [AW-1:0] addr;
        logic [DW-1:0] expv;
        logic [DW-1:0] stat;
        logic [DW-1:0] data;
        logic          verdict;
    } regs_t;

    regs_t     r_d, r_q;
    poll_dec_e dec_w;
    logic      limit_w;
    logic      accept_w;
    logic      tick_w;

    assign accept_w = (r_q.state == ST_IDLE) && start_i;
    assign tick_w   = rd_ack_i &&
                      (r_q.state == ST_READ1 || r_q.state == ST_READ2);

    poll_decide #(
        .DW       (DW),
        .POLL_BIT (DW - 1),
        .TIME_BIT (TIME_BIT)
    ) u_decide (
        .stat_i    (r_q.stat),
        .exp_i     (r_q.expv),
        .recheck_i (r_q.state == ST_CHECK2),
        .limit_i   (limit_w),
        .dec_o     (dec_w)
    );

    poll_wdog #(
        .MAX_READS (MAX_READS)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept_w),
        .tick_i    (tick_w),
        .expired_o (limit_w)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr  = addr_i;
                    r_d.expv  = expect_i;
                    r_d.data  = '0;
                    r_d.state = ST_READ1;
                end
            end
            ST_READ1: begin
                if (rd_ack_i) begin
                    r_d.stat  = rd_data_i;
                    r_d.state = ST_CHECK1;
                end
            end
            ST_READ2: begin
                if (rd_ack_i) begin
                    r_d.stat  = rd_data_i;
                    r_d.state = ST_CHECK2;
                end
            end
            ST_CHECK1, ST_CHECK2: begin
                unique case (dec_w)
                    DEC_FINAL:   r_d.state = ST_FINAL;
                    DEC_RETRY:   r_d.state = ST_READ1;
                    DEC_RECHECK: r_d.state = ST_READ2;
                    default: begin
                        r_d.data    = r_q.stat;
                        r_d.verdict = 1'b0;
                        r_d.state   = ST_DONE;
                    end
                endcase
            end
            ST_FINAL: begin
                if (rd_ack_i) begin
                    r_d.data    = rd_data_i;
                    r_d.verdict = 1'b1;
                    r_d.state   = ST_DONE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, expv: '0, stat: '0,
                     data: '0, verdict: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o  = (r_q.state == ST_READ1) || (r_q.state == ST_READ2) ||
                       (r_q.state == ST_FINAL);
    assign rd_addr_o = r_q.addr;
    assign done_o    = (r_q.state == ST_DONE);
    assign pass_o    = done_o && r_q.verdict;
    assign fail_o    = done_o && !r_q.verdict;
    assign data_o    = r_q.data;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o); // R11

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && $past(rd_req_o) |-> $stable(rd_addr_o)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o)); // R8

    AST_PASS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> $past(rd_ack_i)); // R3

    AST_FAIL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !$past(rd_req_o)); // R6

endmodule

// File: tb/tb_flash_poll_checker.sv
`timescale 1ns/1ps
module tb_flash_poll_checker;

    localparam int AW   = 20;
    localparam int DW   = 8;
    localparam int MAXR = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] expect_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          done_o, pass_o, fail_o;
    logic [DW-1:0] data_o;

    always #2.5 clk = ~clk;

    flash_poll_checker #(.AW(AW), .DW(DW), .TIME_BIT(5), .MAX_READS(MAXR)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .expect_i(expect_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .data_o(data_o));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]    script [0:31];
    int            sidx = 0;
    int            nreads = 0;
    int            bad_addr = 0;
    int            drop_err = 0;
    int            lat = 0;
    int            wcnt = 0;
    bit            pend = 0;
    logic [AW-1:0] cur_addr = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus responder: acks after lat cycles, returns scripted bytes
    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i = 1'b0;
        end else if (rd_req_o) begin
            if (!pend) begin
                pend = 1;
                wcnt = lat;
            end
            if (wcnt == 0) begin
                rd_ack_i  = 1'b1;
                rd_data_i = (sidx < 32) ? script[sidx] : 8'h00;
                sidx++;
                nreads++;
                pend = 0;
                if (rd_addr_o !== cur_addr) bad_addr++;
            end else begin
                wcnt--;
            end
        end else if (pend) begin
            drop_err++;
            pend = 0;
        end
    end

    // bench model of the verdict
    task automatic model(input logic [7:0] e, output bit p, output logic [7:0] d,
                         output int n);
        int i = 0;
        int sr = 0;
        bit fin = 0;
        logic [7:0] b;
        p = 0;
        d = 8'h00;
        while (!fin) begin
            b = script[i]; i++; sr++;
            if (b[7] == e[7]) begin
                d = script[i]; i++; p = 1; fin = 1;
            end else if (b[5]) begin
                b = script[i]; i++; sr++;
                if (b[7] == e[7]) begin
                    d = script[i]; i++; p = 1;
                end else begin
                    d = b; p = 0;
                end
                fin = 1;
            end else if (sr >= MAXR) begin
                d = b; p = 0; fin = 1;
            end
        end
        n = i;
    endtask

    task automatic run_op(input string tag, input logic [AW-1:0] a,
                          input logic [7:0] e, input bit poke);
        bit ep;
        logic [7:0] ed;
        int en;
        int cyc = 0;
        bit got = 0;
        model(e, ep, ed, en);
        sidx = 0; nreads = 0; bad_addr = 0; drop_err = 0;
        cur_addr = a;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; expect_i = e;
        @(negedge clk);
        start_i = 1'b0;
        while (!got && cyc < 300) begin
            if (done_o) begin
                got = 1;
            end else begin
                if (poke && cyc == 3) begin
                    start_i = 1'b1; addr_i = ~a; expect_i = ~e;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        start_i = 1'b0;
        check({tag, " R8 done seen"}, 32'(got), 32'd1);
        check({tag, " R3/R6 pass"}, 32'(pass_o), 32'(ep));
        check({tag, " R6/R9 fail"}, 32'(fail_o), 32'(!ep));
        check({tag, " R3/R6 data_o"}, 32'(data_o), 32'(ed));
        check({tag, " R4/R5 read count"}, 32'(nreads), 32'(en));
        check({tag, " R2 address"}, 32'(bad_addr), 32'd0);
        check({tag, " R11 request held"}, 32'(drop_err), 32'd0);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 32'(done_o), 32'd0);
        check({tag, " R8 data held"}, 32'(data_o), 32'(ed));
        if (poke) begin
            repeat (4) @(negedge clk);
            check({tag, " R10 no second op"}, 32'(rd_req_o | done_o), 32'd0);
        end
    endtask

    task automatic fill(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3);
        for (int i = 0; i < 32; i++) script[i] = 8'h00;
        script[0] = b0; script[1] = b1; script[2] = b2; script[3] = b3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] e;
        seed = $urandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        check("R1 rd_req", 32'(rd_req_o), 32'd0);
        check("R1 done", 32'(done_o | pass_o | fail_o), 32'd0);
        check("R1 data_o", 32'(data_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R7: erase, first read matches, lower bits differ
        lat = 0;
        fill(8'h80, 8'hFF, 8'h11, 8'h22);
        run_op("R3 R7 erase first", 20'h0ABCD, 8'hFF, 0);
        // R7: program with low bits far from expected
        fill(8'h2A, 8'h5C, 8'h00, 8'h00);
        run_op("R7 low bits ignored", 20'h00010, 8'h55, 0);
        // R4: toggles twice, then match
        lat = 2;
        fill(8'h00, 8'h01, 8'h80, 8'h9C);
        run_op("R4 retry", 20'h12345, 8'hFF, 0);
        // R5: bit5 set, recheck matches
        fill(8'h20, 8'hA0, 8'h3C, 8'h00);
        run_op("R5 recheck pass", 20'h54321, 8'hFF, 0);
        // R6: bit5 set, recheck still differs
        lat = 1;
        fill(8'hA0, 8'hE7, 8'h00, 8'h00);
        run_op("R6 recheck fail", 20'h00777, 8'h00, 0);
        // R9: limit reached with distinct bytes
        for (int i = 0; i < 32; i++) script[i] = 8'(i + 1);
        run_op("R9 read limit", 20'h0F0F0, 8'h80, 0);
        // R10: start pulsed while busy
        lat = 3;
        fill(8'h00, 8'h00, 8'h80, 8'h42);
        run_op("R10 busy start", 20'h03333, 8'hFF, 1);

        // constrained random operations
        for (int k = 0; k < 80; k++) begin
            e = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            lat = $urandom % 4;
            for (int i = 0; i < 32; i++) begin
                script[i] = 8'($urandom);
                script[i][7] = (($urandom % 4) == 0) ? e[7] : ~e[7];
                script[i][5] = (($urandom % 4) == 0);
            end
            run_op("R4 R5 random", AW'($urandom), e, (k % 10) == 5);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule